// File: doc/BRIEF.md
# Booth Last-Row Two's Complement Generator

This block builds the final partial product row of a radix-4 Booth-recoded signed multiplier. That row comes out already in two's complement form, so the reduction array needs no extra correction bit for it. It takes the signed multiplicand and the top three-bit Booth window of the multiplier. It returns the whole row, sign-extended to a fixed width, one clock after the inputs are sampled. The row can then go straight into a compressor tree. Removing that correction bit lowers the tallest column of the array by one.

The negation of the multiplicand comes from a parallel-prefix OR tree of logarithmic depth. It is computed alongside the other rows and does not wait on a ripple chain. A decoder turns the Booth window into five mutually exclusive selects for the multiples zero, plus one, minus one, plus two and minus two times the multiplicand. An AND-OR multiplexer per bit picks among the four non-zero multiples and gives zero when none of them is chosen. The doubled multiples are the single multiples shifted left by one place.

The window is written {hi, mid, lo}, with hi as bit 2 of `win_i`. The row is W+2 bits wide. That width holds every multiple exactly, including twice the negated most negative multiplicand.

Top module: `last_row_gen`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises, `row_o` is all zeros.
- R2: For window codes 3'b000 and 3'b111 the row registered at the next edge is zero.
- R3: For window codes 3'b001 and 3'b010 the registered row equals the multiplicand sign-extended to W+2 bits.
- R4: For window code 3'b011 the registered row equals twice the multiplicand, as a W+2-bit two's complement value.
- R5: For window code 3'b100 the registered row equals minus twice the multiplicand, as a W+2-bit two's complement value.
- R6: For window codes 3'b101 and 3'b110 the registered row equals minus the multiplicand, and the negation tree always returns the exact two's complement negation of the sign-extended multiplicand.
- R7: Results are exact for the extreme multiplicands: for the most negative X, minus two times X is +2^W, and that value is representable in the W+2-bit row.
- R8: Exactly one of the five multiple selects is active in every cycle. A new window applied each cycle therefore gives a row that depends only on the inputs at the last edge, with nothing left over from earlier windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_i | input | W | Signed multiplicand |
| win_i | input | 3 | Booth window {hi, mid, lo} from the top of the multiplier |
| row_o | output | W+2 | Registered last partial product row, two's complement, sign-extended |

## Verification
The assertions check on every cycle that exactly one multiple select is active. They also check that the prefix negation tree's output added to the sign-extended multiplicand wraps to zero. For each window class, they check that the registered row has the right relation to the multiplicand sampled one edge earlier. Only the bench's scenarios can show that the extreme multiplicands (most negative, most positive, zero, minus one) give exact rows at the widest magnitudes. The same holds for window codes that change every cycle, where the bench shows each row carries no trace of an earlier window.

// File: rtl/last_row_pkg.sv
package last_row_pkg;

    // One-hot selection of the Booth multiple for the last row.
    typedef struct packed {
        logic zero;
        logic pos1;
        logic neg1;
        logic pos2;
        logic neg2;
    } mult_sel_t;

    localparam int SEL_W = 5;

endpackage

// File: rtl/booth_sel_decoder.sv
module booth_sel_decoder
    import last_row_pkg::*;
(
    input  logic [2:0] win_i,
    output mult_sel_t  sel_o
);

    always_comb begin
        sel_o = '0;
        unique case (win_i)
            3'b000, 3'b111: sel_o.zero = 1'b1;
            3'b001, 3'b010: sel_o.pos1 = 1'b1;
            3'b011:         sel_o.pos2 = 1'b1;
            3'b100:         sel_o.neg2 = 1'b1;
            3'b101, 3'b110: sel_o.neg1 = 1'b1;
            default:        sel_o.zero = 1'b1;
        endcase
    end

endmodule

// File: rtl/prefix_negate.sv
// Two's complement negation in logarithmic depth:
// bit i of -a is a[i] XOR (OR of all bits below i).
// The OR prefix is built as a Kogge-Stone style tree.
module prefix_negate #(
    parameter int N = 10
) (
    input  logic [N-1:0] a_i,
    output logic [N-1:0] neg_o
);

    localparam int LEVELS = (N > 1) ? $clog2(N) : 1;

    logic [LEVELS:0][N-1:0] pre;

    assign pre[0] = a_i;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int SPAN = 1 << l;
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (i >= SPAN) begin : g_comb
                assign pre[l+1][i] = pre[l][i] | pre[l][i-SPAN];
            end else begin : g_pass
                assign pre[l+1][i] = pre[l][i];
            end
        end
    end

    assign neg_o[0] = a_i[0];
    for (genvar i = 1; i < N; i++) begin : g_out
        assign neg_o[i] = a_i[i] ^ pre[LEVELS][i-1];
    end

endmodule

// File: rtl/row_select_mux.sv
module row_select_mux
    import last_row_pkg::*;
#(
    parameter int N = 10
) (
    input  mult_sel_t    sel_i,
    input  logic [N-1:0] pos1_i,
    input  logic [N-1:0] neg1_i,
    input  logic [N-1:0] pos2_i,
    input  logic [N-1:0] neg2_i,
    output logic [N-1:0] row_o
);

    // Per-bit AND-OR selector; yields zero when no non-zero multiple is picked.
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign row_o[i] = ~sel_i.zero &
                          ((sel_i.pos1 & pos1_i[i]) |
                           (sel_i.neg1 & neg1_i[i]) |
                           (sel_i.pos2 & pos2_i[i]) |
                           (sel_i.neg2 & neg2_i[i]));
    end

endmodule

// File: rtl/last_row_gen.sv
module last_row_gen
    import last_row_pkg::*;
#(
    parameter int W = 8,
    localparam int ROW_W = W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     x_i,
    input  logic [2:0]       win_i,
    output logic [ROW_W-1:0] row_o
);

    typedef struct packed {
        logic [ROW_W-1:0] row;
    } state_t;

    state_t state_d, state_q;

    mult_sel_t        sel;
    logic [ROW_W-1:0] x_ext;
    logic [ROW_W-1:0] neg_x;
    logic [ROW_W-1:0] pos2_x;
    logic [ROW_W-1:0] neg2_x;
    logic [ROW_W-1:0] row_sel;

    assign x_ext  = {{2{x_i[W-1]}}, x_i};
    assign pos2_x = {x_ext[ROW_W-2:0], 1'b0};
    assign neg2_x = {neg_x[ROW_W-2:0], 1'b0};

    booth_sel_decoder i_dec (
        .win_i (win_i),
        .sel_o (sel)
    );

    prefix_negate #(.N(ROW_W)) i_neg (
        .a_i   (x_ext),
        .neg_o (neg_x)
    );

    row_select_mux #(.N(ROW_W)) i_mux (
        .sel_i  (sel),
        .pos1_i (x_ext),
        .neg1_i (neg_x),
        .pos2_i (pos2_x),
        .neg2_i (neg2_x),
        .row_o  (row_sel)
    );

    always_comb begin
        state_d     = state_q;
        state_d.row = row_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign row_o = state_q.row;

endmodule

// File: rtl/last_row_chk.sv
module last_row_chk
    import last_row_pkg::*;
#(
    parameter int W = 8,
    localparam int ROW_W = W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     x_i,
    input logic [2:0]       win_i,
    input logic [ROW_W-1:0] row_o,
    input mult_sel_t        sel_i,
    input logic [ROW_W-1:0] neg_i
);

    logic [ROW_W-1:0] xe;
    assign xe = {{2{x_i[W-1]}}, x_i};

    // R1
    reset_row_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> row_o == '0);

    // R2
    zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i == 3'b000 || win_i == 3'b111) |=> row_o == '0);

    // R3
    plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i == 3'b001 || win_i == 3'b010) |=> row_o == $past(xe));

    // R4
    plus_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i == 3'b011) |=> row_o == {$past(xe[ROW_W-2:0]), 1'b0});

    // R5
    minus_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i == 3'b100) |=> ROW_W'(row_o + {$past(xe[ROW_W-2:0]), 1'b0}) == '0);

    // R6
    minus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i == 3'b101 || win_i == 3'b110) |=> ROW_W'(row_o + $past(xe)) == '0);

    // R6
    negate_tree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ROW_W'(neg_i + xe) == '0);

    // R8
    select_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_i) == 1);

endmodule

bind last_row_gen last_row_chk #(.W(W)) i_last_row_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .x_i   (x_i),
    .win_i (win_i),
    .row_o (row_o),
    .sel_i (sel),
    .neg_i (neg_x)
);

// File: tb/test_last_row_gen.sv
module test_last_row_gen;

    localparam int W     = 8;
    localparam int ROW_W = W + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     x_i = '0;
    logic [2:0]       win_i = '0;
    logic [ROW_W-1:0] row_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    last_row_gen #(.W(W)) i_last_row_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .x_i   (x_i),
        .win_i (win_i),
        .row_o (row_o)
    );

    function automatic int booth_digit(input logic [2:0] w);
        case (w)
            3'b001, 3'b010: return 1;
            3'b011:         return 2;
            3'b100:         return -2;
            3'b101, 3'b110: return -1;
            default:        return 0;
        endcase
    endfunction

    function automatic string req_tag(input logic [2:0] w);
        case (w)
            3'b001, 3'b010: return "R3";
            3'b011:         return "R4";
            3'b100:         return "R5";
            3'b101, 3'b110: return "R6";
            default:        return "R2";
        endcase
    endfunction

    function automatic logic [ROW_W-1:0] expect_row(input logic [W-1:0] x, input logic [2:0] w);
        longint v;
        v = longint'($signed(x)) * longint'(booth_digit(w));
        return v[ROW_W-1:0];
    endfunction

    task automatic check(input string tag, input logic [ROW_W-1:0] got, input logic [ROW_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: row_o=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive on falling edge, capture at rising edge, compare at next falling edge.
    task automatic apply(input logic [W-1:0] x, input logic [2:0] w, input string tag);
        x_i   = x;
        win_i = w;
        @(negedge clk);
        check(tag, row_o, expect_row(x, w));
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: row_o=%h expected=finished run", row_o);
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17_0C3E));
        x_i   = 8'h80;
        win_i = 3'b100;
        repeat (3) @(negedge clk);
        check("R1 in reset", row_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // first edge with reset released captured the applied inputs
        check("R1 after release", row_o, expect_row(8'h80, 3'b100));

        // Directed extremes for every window code.
        for (int w = 0; w < 8; w++) begin
            apply(8'h80, 3'(w), "R7 most negative");
            apply(8'h7F, 3'(w), "R7 most positive");
            apply(8'h00, 3'(w), req_tag(3'(w)));
            apply(8'hFF, 3'(w), req_tag(3'(w)));
        end

        // -2 * most negative must give +2^W exactly.
        apply(8'h80, 3'b100, "R7 -2X of min");
        check("R7 value 2^W", row_o, ROW_W'(1 << W));

        // Back-to-back window changes with no idle cycles.
        for (int k = 0; k < 64; k++) begin
            apply(8'(k * 37 + 5), 3'(k), "R8 back-to-back");
        end

        // Constrained random: bias towards edge multiplicands.
        for (int k = 0; k < 600; k++) begin
            logic [W-1:0] x;
            logic [2:0]   w;
            case ($urandom_range(0, 7))
                0:       x = 8'h80;
                1:       x = 8'h7F;
                2:       x = 8'h01;
                default: x = 8'($urandom);
            endcase
            w = 3'($urandom);
            apply(x, w, req_tag(w));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule